// File: doc/BRIEF.md
# Time-of-Day Counter with Fractional Rate and Event Capture

This block keeps a free-running time of day made of a 48-bit seconds count and a 30-bit nanoseconds count. On every clock it adds a programmable step with an integer nanosecond part and a 16-bit fractional part. The fractional part is summed in its own accumulator. When that accumulator carries out, the block adds one more nanosecond in that cycle. Software trims the frequency by changing the step, and it moves the time by loading new values or by writing a one-shot signed offset.

Register access is a single write port and a combinational read port, both addressed with three bits. The seconds are loaded in two words. The upper word waits in a holding register until the lower word is written, and then both take effect together. The fractional step likewise waits in a holding register until the integer step is written.

A one-cycle event strobe freezes the nanoseconds and the low seconds bits of the current time, together with a valid flag. Software reads this flag, and a read of the status word clears it.

Top module: `tod_counter`

## Requirements
- R1: After reset the seconds, nanoseconds and fraction accumulator are zero. The live step and the fraction holding register hold the nominal rate computed from CLK_HZ: integer part = NS_LIMIT / CLK_HZ, fraction = ((NS_LIMIT mod CLK_HZ) * 65536) / CLK_HZ. The capture valid flag (bit 31 at address 7) is clear.
- R2: Each cycle the live step fraction is added to a 16-bit accumulator. The time advances by the integer step plus that addition's carry. Nanoseconds wrap at NS_LIMIT (default 1e9) and carry into seconds. Seconds wrap from 2^48-1 to 0.
- R3: A write to address 4 (data[15:0]) only changes the fraction holding register, which reads back at address 4. A write to address 3 (data[7:0]) sets the integer step and copies the held fraction into the live step. The new step is used from the next cycle on. Address 3 reads {8'h00, integer[7:0], fraction[15:0]}.
- R4: While both live step fields are zero and no write occurs, the time does not change.
- R5: A write to address 2 (data[15:0]) only holds the upper seconds word, and address 2 keeps reading the live seconds[47:32]. A write to address 1 loads seconds with {held upper word, data[31:0]}. In that cycle the nanoseconds still advance, but their wrap does not alter the loaded seconds.
- R6: A write to address 0 loads nanoseconds from data[29:0]. In that cycle the seconds do not change, even when the normal advance would have wrapped.
- R7: A write to address 5 applies a one-shot offset on top of that cycle's advance. Bit 31 set means subtract and clear means add. The magnitude sits in data[29:0] and is below NS_LIMIT. A wrap up carries into seconds, and a wrap below zero borrows from seconds.
- R8: When evt_strobe is high, the block captures the nanoseconds and seconds[5:0] visible in that cycle. Address 6 reads the captured nanoseconds. Address 7 reads {valid at bit 31, captured seconds at [5:0]}. A strobe sets the valid flag. A read with rd_en at address 7 clears it, unless a strobe occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (read side effects only) |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Combinational read data |
| evt_strobe | input | 1 | One-cycle event capture strobe |

## Verification
A wrong fraction accumulator shows at the nanosecond read as a one-count slip. It appears within a few cycles, and the slip grows without bound over a long sweep, so every cycle of every run is compared against an arithmetic time model. A wrong holding register for the upper seconds word or the fraction stays hidden until the committing write. For that reason, each holding-register test reads back the live value before the commit and again right after it. Carry and borrow errors appear only at the exact cycle where nanoseconds cross NS_LIMIT or zero, so the bench loads values a few counts from each edge, including the top of the seconds range.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 3;
    localparam int ADJ_SIGN_BIT = 31;

    typedef enum logic [ADDR_W-1:0] {
        REG_NS       = 3'd0,
        REG_SEC_LO   = 3'd1,
        REG_SEC_HI   = 3'd2,
        REG_INC_NS   = 3'd3,
        REG_INC_FRAC = 3'd4,
        REG_ADJ      = 3'd5,
        REG_CAP_NS   = 3'd6,
        REG_CAP_SEC  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/tod_frac_acc.sv
module tod_frac_acc #(
    parameter int FRAC_W = 16,
    parameter int INC_W  = 8
) (
    input  logic [FRAC_W-1:0] acc_q,
    input  logic [FRAC_W-1:0] frac,
    input  logic [INC_W-1:0]  inc_ns,
    output logic [FRAC_W-1:0] acc_d,
    output logic [INC_W:0]    step
);
    logic [FRAC_W:0] sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac};
        acc_d = sum[FRAC_W-1:0];
        step  = {1'b0, inc_ns} + {{INC_W{1'b0}}, sum[FRAC_W]};
    end
endmodule

// File: rtl/tod_ns_fold.sv
module tod_ns_fold #(
    parameter int          NS_W  = 30,
    parameter int unsigned LIMIT = 1_000_000_000
) (
    input  logic [NS_W-1:0] ns_in,
    input  logic [NS_W-1:0] delta,
    input  logic            sub,
    output logic [NS_W-1:0] ns_out,
    output logic            wrap_up,
    output logic            wrap_down
);
    localparam logic [NS_W:0] LIM = (NS_W+1)'(LIMIT);

    logic [NS_W:0] sum;
    logic [NS_W:0] diff;
    logic [NS_W:0] lifted;

    always_comb begin
        sum       = {1'b0, ns_in} + {1'b0, delta};
        diff      = {1'b0, ns_in} - {1'b0, delta};
        lifted    = diff + LIM;
        wrap_up   = 1'b0;
        wrap_down = 1'b0;
        if (sub) begin
            if (ns_in >= delta) begin
                ns_out = diff[NS_W-1:0];
            end else begin
                ns_out    = lifted[NS_W-1:0];
                wrap_down = 1'b1;
            end
        end else if (sum >= LIM) begin
            ns_out  = NS_W'(sum - LIM);
            wrap_up = 1'b1;
        end else begin
            ns_out = sum[NS_W-1:0];
        end
    end
endmodule

// File: rtl/tod_capture.sv
module tod_capture #(
    parameter int NS_W      = 30,
    parameter int CAP_SEC_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe,
    input  logic                 clear,
    input  logic [NS_W-1:0]      ns_now,
    input  logic [CAP_SEC_W-1:0] sec_now,
    output logic [NS_W-1:0]      cap_ns,
    output logic [CAP_SEC_W-1:0] cap_sec,
    output logic                 cap_valid
);
    typedef struct packed {
        logic [NS_W-1:0]      ns;
        logic [CAP_SEC_W-1:0] sec;
        logic                 valid;
    } cap_state_t;

    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (strobe) begin
            cap_d.ns    = ns_now;
            cap_d.sec   = sec_now;
            cap_d.valid = 1'b1;
        end else if (clear) begin
            cap_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_ns    = cap_q.ns;
    assign cap_sec   = cap_q.sec;
    assign cap_valid = cap_q.valid;
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
    parameter int          SEC_W     = 48,
    parameter int          NS_W      = 30,
    parameter int          INC_W     = 8,
    parameter int          FRAC_W    = 16,
    parameter int          CAP_SEC_W = 6,
    parameter int unsigned NS_LIMIT  = 1_000_000_000,
    parameter int unsigned CLK_HZ    = 125_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        evt_strobe
);
    import tod_pkg::*;

    localparam int SEC_LO_W = 32;
    localparam int SEC_HI_W = SEC_W - SEC_LO_W;
    localparam longint unsigned INC_RST_L  = longint'(NS_LIMIT) / longint'(CLK_HZ);
    localparam longint unsigned REM_L      = longint'(NS_LIMIT) % longint'(CLK_HZ);
    localparam longint unsigned FRAC_RST_L = (REM_L << FRAC_W) / longint'(CLK_HZ);
    localparam logic [INC_W-1:0]  INC_RST  = INC_W'(INC_RST_L);
    localparam logic [FRAC_W-1:0] FRAC_RST = FRAC_W'(FRAC_RST_L);

    typedef struct packed {
        logic [SEC_W-1:0]    sec;
        logic [NS_W-1:0]     ns;
        logic [FRAC_W-1:0]   acc;
        logic [INC_W-1:0]    inc_ns;
        logic [FRAC_W-1:0]   inc_frac;
        logic [FRAC_W-1:0]   frac_stage;
        logic [SEC_HI_W-1:0] sec_hi_pend;
    } tod_state_t;

    tod_state_t st_d, st_q;

    // fraction accumulator and step
    logic [FRAC_W-1:0] acc_nx;
    logic [INC_W:0]    step;

    tod_frac_acc #(.FRAC_W(FRAC_W), .INC_W(INC_W)) u_frac (
        .acc_q  (st_q.acc),
        .frac   (st_q.inc_frac),
        .inc_ns (st_q.inc_ns),
        .acc_d  (acc_nx),
        .step   (step)
    );

    // first fold: regular advance
    logic [NS_W-1:0] ns_tick;
    logic            tick_up, tick_down;

    tod_ns_fold #(.NS_W(NS_W), .LIMIT(NS_LIMIT)) u_fold_tick (
        .ns_in     (st_q.ns),
        .delta     (NS_W'(step)),
        .sub       (1'b0),
        .ns_out    (ns_tick),
        .wrap_up   (tick_up),
        .wrap_down (tick_down)
    );

    // second fold: one-shot offset
    logic            adj_on;
    logic [NS_W-1:0] adj_mag;
    logic [NS_W-1:0] ns_adj;
    logic            adj_up, adj_down;

    assign adj_on  = wr_en && (reg_addr_e'(wr_addr) == REG_ADJ);
    assign adj_mag = adj_on ? wr_data[NS_W-1:0] : '0;

    tod_ns_fold #(.NS_W(NS_W), .LIMIT(NS_LIMIT)) u_fold_adj (
        .ns_in     (ns_tick),
        .delta     (adj_mag),
        .sub       (adj_on && wr_data[ADJ_SIGN_BIT]),
        .ns_out    (ns_adj),
        .wrap_up   (adj_up),
        .wrap_down (adj_down)
    );

    logic [SEC_W-1:0] sec_run;

    always_comb begin
        sec_run = st_q.sec + SEC_W'(tick_up) + SEC_W'(adj_up)
                - SEC_W'(tick_down) - SEC_W'(adj_down);

        st_d     = st_q;
        st_d.acc = acc_nx;
        st_d.ns  = ns_adj;
        st_d.sec = sec_run;

        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                REG_NS: begin
                    st_d.ns  = wr_data[NS_W-1:0];
                    st_d.sec = st_q.sec;
                end
                REG_SEC_LO:   st_d.sec         = {st_q.sec_hi_pend, wr_data};
                REG_SEC_HI:   st_d.sec_hi_pend = wr_data[SEC_HI_W-1:0];
                REG_INC_FRAC: st_d.frac_stage  = wr_data[FRAC_W-1:0];
                REG_INC_NS: begin
                    st_d.inc_ns   = wr_data[INC_W-1:0];
                    st_d.inc_frac = st_q.frac_stage;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.inc_ns     <= INC_RST;
            st_q.inc_frac   <= FRAC_RST;
            st_q.frac_stage <= FRAC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // capture
    logic [NS_W-1:0]      cap_ns;
    logic [CAP_SEC_W-1:0] cap_sec;
    logic                 cap_valid;

    tod_capture #(.NS_W(NS_W), .CAP_SEC_W(CAP_SEC_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (evt_strobe),
        .clear     (rd_en && (reg_addr_e'(rd_addr) == REG_CAP_SEC)),
        .ns_now    (st_q.ns),
        .sec_now   (st_q.sec[CAP_SEC_W-1:0]),
        .cap_ns    (cap_ns),
        .cap_sec   (cap_sec),
        .cap_valid (cap_valid)
    );

    // read mux
    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            REG_NS:       rd_data = 32'(st_q.ns);
            REG_SEC_LO:   rd_data = st_q.sec[SEC_LO_W-1:0];
            REG_SEC_HI:   rd_data = 32'(st_q.sec[SEC_W-1:SEC_LO_W]);
            REG_INC_NS:   rd_data = 32'({st_q.inc_ns, st_q.inc_frac});
            REG_INC_FRAC: rd_data = 32'(st_q.frac_stage);
            REG_ADJ:      rd_data = '0;
            REG_CAP_NS:   rd_data = 32'(cap_ns);
            REG_CAP_SEC:  rd_data = {cap_valid, 31'(cap_sec)};
            default:      rd_data = '0;
        endcase
    end

    // flat views for the checker
    logic [SEC_W-1:0]    live_sec;
    logic [NS_W-1:0]     live_ns;
    logic [INC_W-1:0]    live_inc_ns;
    logic [FRAC_W-1:0]   live_inc_frac;
    logic [FRAC_W-1:0]   live_stage;
    logic [SEC_HI_W-1:0] live_pend;

    assign live_sec      = st_q.sec;
    assign live_ns       = st_q.ns;
    assign live_inc_ns   = st_q.inc_ns;
    assign live_inc_frac = st_q.inc_frac;
    assign live_stage    = st_q.frac_stage;
    assign live_pend     = st_q.sec_hi_pend;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
    parameter int          SEC_W    = 48,
    parameter int          NS_W     = 30,
    parameter int          INC_W    = 8,
    parameter int          FRAC_W   = 16,
    parameter int unsigned NS_LIMIT = 1_000_000_000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          wr_addr,
    input logic [31:0]         wr_data,
    input logic                rd_en,
    input logic [2:0]          rd_addr,
    input logic                evt_strobe,
    input logic [SEC_W-1:0]    live_sec,
    input logic [NS_W-1:0]     live_ns,
    input logic [INC_W-1:0]    live_inc_ns,
    input logic [FRAC_W-1:0]   live_inc_frac,
    input logic [FRAC_W-1:0]   live_stage,
    input logic [SEC_W-33:0]   live_pend,
    input logic                cap_valid
);
    import tod_pkg::*;

    a_r2_ns_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        live_ns < NS_W'(NS_LIMIT));

    a_r4_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (live_inc_ns == '0 && live_inc_frac == '0 && !wr_en)
        |=> ($stable(live_ns) && $stable(live_sec)));

    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_INC_NS)
        |=> (live_inc_frac == $past(live_stage) && live_inc_ns == $past(wr_data[INC_W-1:0])));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == REG_INC_NS)
        |=> ($stable(live_inc_frac) && $stable(live_inc_ns)));

    a_r5_lo_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_SEC_LO)
        |=> (live_sec == {$past(live_pend), $past(wr_data)}));

    a_r6_ns_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_NS)
        |=> (live_ns == $past(wr_data[NS_W-1:0]) && $stable(live_sec)));

    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_strobe |=> cap_valid);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == REG_CAP_SEC && !evt_strobe) |=> !cap_valid);
endmodule

bind tod_counter tod_counter_chk #(
    .SEC_W    (SEC_W),
    .NS_W     (NS_W),
    .INC_W    (INC_W),
    .FRAC_W   (FRAC_W),
    .NS_LIMIT (NS_LIMIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .evt_strobe    (evt_strobe),
    .live_sec      (live_sec),
    .live_ns       (live_ns),
    .live_inc_ns   (live_inc_ns),
    .live_inc_frac (live_inc_frac),
    .live_stage    (live_stage),
    .live_pend     (live_pend),
    .cap_valid     (cap_valid)
);

// File: tb/tod_counter_test.sv
module tod_counter_test;
    localparam int unsigned NPS   = 1000;
    localparam int unsigned HZ    = 300;
    localparam longint      NPS_L = 1000;
    localparam longint      SPAN  = 64'sd1 << 48;
    localparam longint      FULL  = SPAN * NPS_L;
    localparam logic [31:0] SUB   = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        evt = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    tod_counter #(.NS_LIMIT(NPS), .CLK_HZ(HZ)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .evt_strobe (evt)
    );

    always #10 clk = ~clk;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    longint m_t;
    longint m_acc, m_inc, m_frac, m_stage, m_pend, m_cap_ns, m_cap_sec;
    bit     m_cap_v;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output longint v);
        rd_addr = a;
        #1;
        v = longint'(rd_data);
    endtask

    task automatic check_time(input string req);
        longint v, sec;
        sec = m_t / NPS_L;
        peek(3'd0, v); check({req, " ns"}, v, m_t % NPS_L);
        peek(3'd1, v); check({req, " sec_lo"}, v, sec & 64'hFFFF_FFFF);
        peek(3'd2, v); check({req, " sec_hi"}, v, sec >> 32);
    endtask

    task automatic model_tick(input bit wr, input logic [2:0] a, input logic [31:0] d,
                              input bit rd, input logic [2:0] ra, input bit ev);
        longint step, sec_o, ns_n, dd;
        dd = longint'(d);
        if (ev) begin
            m_cap_ns  = m_t % NPS_L;
            m_cap_sec = (m_t / NPS_L) & 63;
            m_cap_v   = 1'b1;
        end else if (rd && ra == 3'd7) begin
            m_cap_v = 1'b0;
        end
        m_acc = m_acc + m_frac;
        step  = m_inc + (m_acc >> 16);
        m_acc = m_acc & 64'hFFFF;
        sec_o = m_t / NPS_L;
        if (wr && a == 3'd0) begin
            m_t = sec_o * NPS_L + (dd & 64'h3FFF_FFFF);
        end else if (wr && a == 3'd1) begin
            ns_n = (m_t + step) % NPS_L;
            m_t  = ((m_pend << 32) | dd) * NPS_L + ns_n;
        end else begin
            m_t = m_t + step;
            if (wr && a == 3'd5) begin
                if (d[31]) m_t = m_t - (dd & 64'h3FFF_FFFF);
                else       m_t = m_t + (dd & 64'h3FFF_FFFF);
            end
        end
        if (wr && a == 3'd2) m_pend  = dd & 64'hFFFF;
        if (wr && a == 3'd4) m_stage = dd & 64'hFFFF;
        if (wr && a == 3'd3) begin
            m_inc  = dd & 64'hFF;
            m_frac = m_stage;
        end
        if (m_t >= FULL) m_t = m_t - FULL;
        if (m_t < 0)     m_t = m_t + FULL;
    endtask

    task automatic cyc(input bit wr, input logic [2:0] a, input logic [31:0] d,
                       input bit rd, input logic [2:0] ra, input bit ev);
        wr_en = wr; wr_addr = a; wr_data = d;
        rd_en = rd; rd_addr = ra; evt = ev;
        @(posedge clk);
        model_tick(wr, a, d, rd, ra, ev);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; evt = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 3'd0, 1'b0);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 3'd0, 32'd0, 1'b0, 3'd0, 1'b0);
            check_time(req);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        longint v;
        m_t = 0; m_acc = 0; m_pend = 0;
        m_inc   = longint'(NPS / HZ);
        m_frac  = (longint'(NPS % HZ) << 16) / longint'(HZ);
        m_stage = m_frac;
        m_cap_ns = 0; m_cap_sec = 0; m_cap_v = 1'b0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_time("R1");
        peek(3'd3, v); check("R1 step", v, (m_inc << 16) | m_frac);
        peek(3'd4, v); check("R1 stage", v, m_stage);
        peek(3'd7, v); check("R1 capture valid", v, 0);

        // R2: long sweep at the nominal fractional rate
        run(700, "R2");

        // R3: staged fraction has no effect until the integer write
        wr(3'd4, 32'd0);
        peek(3'd3, v); check("R3 step unchanged", v, (m_inc << 16) | m_frac);
        peek(3'd4, v); check("R3 stage", v, 0);
        run(40, "R3");
        wr(3'd3, 32'd7);
        peek(3'd3, v); check("R3 committed", v, 64'd7 << 16);
        run(40, "R3");
        wr(3'd4, 32'h4000);
        wr(3'd3, 32'd2);
        run(40, "R3");

        // R5: upper seconds word held until the low word commits
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd1);
        check_time("R5 held");
        run(3, "R5");
        wr(3'd1, 32'hFFFF_FFFF);
        check_time("R5 commit");
        wr(3'd0, 32'd990);
        run(10, "R5");

        // R2: top of the seconds range wraps to zero
        wr(3'd0, 32'd0);
        wr(3'd2, 32'hFFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd0, 32'd995);
        run(10, "R2");

        // R6: nanosecond load suppresses the carry of that cycle
        wr(3'd0, 32'd999);
        wr(3'd0, 32'd5);
        check_time("R6");
        run(3, "R6");

        // R7: signed one-shot offsets
        wr(3'd5, 32'd500);       check_time("R7 add");
        wr(3'd5, SUB | 32'd700); check_time("R7 sub");
        wr(3'd5, 32'd999);       check_time("R7 add wrap");
        wr(3'd5, SUB | 32'd999); check_time("R7 sub wrap");
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd0, 32'd10);
        wr(3'd5, SUB | 32'd100); check_time("R7 borrow below zero");
        run(5, "R7");

        // R4: both step fields zero stop the count
        wr(3'd4, 32'd0);
        wr(3'd3, 32'd0);
        run(20, "R4");
        wr(3'd5, 32'd300);
        check_time("R4 offset while halted");
        run(5, "R4");

        // R2: fraction-only step, one count every second cycle
        wr(3'd4, 32'h8000);
        wr(3'd3, 32'd0);
        run(20, "R2");

        // R8: event capture
        wr(3'd4, 32'(m_frac));
        wr(3'd4, 32'd21845);
        wr(3'd3, 32'd3);
        run(137, "R8");
        cyc(1'b0, 3'd0, 32'd0, 1'b0, 3'd0, 1'b1);
        peek(3'd6, v); check("R8 cap ns", v, m_cap_ns);
        peek(3'd7, v); check("R8 cap sec", v, (longint'(m_cap_v) << 31) | m_cap_sec);
        run(30, "R8");
        peek(3'd6, v); check("R8 cap ns held", v, m_cap_ns);
        cyc(1'b0, 3'd0, 32'd0, 1'b1, 3'd7, 1'b0);
        peek(3'd7, v); check("R8 cleared", v, m_cap_sec);
        cyc(1'b0, 3'd0, 32'd0, 1'b1, 3'd7, 1'b1);
        peek(3'd7, v); check("R8 strobe beats clear", v, (longint'(m_cap_v) << 31) | m_cap_sec);
        peek(3'd6, v); check("R8 recapture ns", v, m_cap_ns);
        run(5, "R8");

        finish_up();
    end
endmodule